// File: doc/BRIEF.md
# Synthesizer frequency-word encoder

This block converts a requested pixel-clock frequency into the 13-bit programming word of a serial frequency synthesizer. The frequency is an integer in units of 0.01 MHz. It is presented on `freq` together with a one-cycle `start` strobe. The block first checks the value against the allowed band. It then doubles the value until it reaches the VCO band, doubling a power-of-two post-divider at each step. Next it scales the result by the reference ratio, rounding to the nearest integer. Last, it removes the feedback offset and packs the post-divider code and the stop bits into the word.

Both divisions share one iterative restoring divider with a 32-bit dividend, so each result takes a few dozen cycles. When the word is ready, `done` pulses for one cycle. `word`, `pdiv` and `err` keep their values until the next result. A value out of range completes at once: `err` is set, and both the word and the divider are zero.

Top module: `fsyn_word_enc`

## Requirements
- R1: A start with `freq` above 15938 completes with `done` and `err` both high, `word` = 0 and `pdiv` = 0.
- R2: A start with `freq` below 1000 completes in the same way as R1. The limits 1000 and 15938 are both accepted.
- R3: For an accepted value v, v is doubled while it is below 8000, and the divider starts at 1 and doubles with v. `pdiv` reports the final divider as the value 1, 2, 4 or 8.
- R4: N = ((v_norm*46000)/1432 + 500)/1000, using integer division. `word[8:0]` holds N-257, so v_norm = 8000 gives 0 and v = 1999 gives 0x101.
- R5: `word[10:9]` is the divider code: 2'b11 for divide-by-1, 2'b10 for 2, 2'b01 for 4 and 2'b00 for 8.
- R6: `word[12:11]` is 2'b11 in every valid result, and `err` is 0.
- R7: `done` is high for exactly one cycle per result. The outputs hold their values after it.
- R8: A start that arrives while a conversion is in progress is ignored. Only the first request produces a result.
- R9: A synchronous, active-high reset clears all outputs and abandons any conversion in progress. No `done` follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| freq | input | 16 | Requested frequency, 0.01 MHz units |
| word | output | 13 | Synthesizer programming word |
| pdiv | output | 4 | Chosen post-divider (1, 2, 4, 8) |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Range failure flag |

## Verification
The hardest case to reach from the ports is a request that arrives while the divider is still working, because the block shows no busy signal. The bench sends a second start with a very different frequency a few cycles after the first. It then checks three things: the single result belongs to the first request, exactly one `done` appears, and nothing else arrives during a long idle window afterward. The bench also applies reset in the middle of a division, to confirm that the pending result is dropped. Near-limit inputs such as 1999 and 3999 are included because their normalised values lie just below 16000.

// File: rtl/fsyn_word_enc.sv
module fsyn_word_enc #(
  parameter int FW       = 16,
  parameter int DW       = 32,
  parameter int F_MAX    = 15938,
  parameter int F_MIN    = 1000,
  parameter int VCO_LO   = 8000,
  parameter int REF_DIV  = 46,
  parameter int REF_FREQ = 1432,
  parameter int SCALE    = 1000,
  parameter int N_ADJ    = 257
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] freq,
  output logic [12:0]   word,
  output logic [3:0]    pdiv,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  typedef enum logic [1:0] {S_IDLE, S_NORM, S_DIV1, S_DIV2} state_t;
  state_t state;

  logic [FW-1:0] val;
  logic [3:0]    pd;
  logic [DW-1:0] quo;
  logic [DW-2:0] rem;
  logic [CW-1:0] cnt;

  logic [DW-1:0] dvs, shifted, r_next, q_next;
  logic          ge;
  logic [1:0]    code;
  logic [8:0]    fld;

  assign dvs     = (state == S_DIV1) ? DW'(REF_FREQ) : DW'(SCALE);
  assign shifted = {rem, quo[DW-1]};
  assign ge      = shifted >= dvs;
  assign r_next  = ge ? shifted - dvs : shifted;
  assign q_next  = {quo[DW-2:0], ge};
  assign fld     = 9'(q_next - DW'(N_ADJ));

  always_comb begin
    case (pd)
      4'd1:    code = 2'b11;
      4'd2:    code = 2'b10;
      4'd4:    code = 2'b01;
      default: code = 2'b00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      val   <= '0;
      pd    <= '0;
      quo   <= '0;
      rem   <= '0;
      cnt   <= '0;
      word  <= '0;
      pdiv  <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (freq > FW'(F_MAX) || freq < FW'(F_MIN)) begin
            word <= '0;
            pdiv <= '0;
            err  <= 1'b1;
            done <= 1'b1;
          end else begin
            val   <= freq;
            pd    <= 4'd1;
            state <= S_NORM;
          end
        end
        S_NORM: begin
          if (val < FW'(VCO_LO)) begin
            val <= val << 1;
            pd  <= pd << 1;
          end else begin
            quo   <= DW'(val) * DW'(REF_DIV * SCALE);
            rem   <= '0;
            cnt   <= '0;
            state <= S_DIV1;
          end
        end
        S_DIV1: begin
          quo <= q_next;
          rem <= (DW-1)'(r_next);
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            quo   <= q_next + DW'(SCALE / 2);
            rem   <= '0;
            state <= S_DIV2;
          end
        end
        S_DIV2: begin
          quo <= q_next;
          rem <= (DW-1)'(r_next);
          cnt <= cnt + 1'b1;
          if (cnt == LAST) begin
            word  <= {2'b11, code, fld};
            pdiv  <= pd;
            err   <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r1_err_clears: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (word == 13'd0 && pdiv == 4'd0));
  a_r6_stop_bits: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> (word[12:11] == 2'b11));
  a_r3_pdiv_onehot: assert property (@(posedge clk) disable iff (rst)
    (done && !err) |-> ($countones(pdiv) == 1 && pdiv[3:0] != 4'd0));
  a_r5_code_div1: assert property (@(posedge clk) disable iff (rst)
    (done && !err && pdiv == 4'd1) |-> (word[10:9] == 2'b11));
  a_r5_code_div8: assert property (@(posedge clk) disable iff (rst)
    (done && !err && pdiv == 4'd8) |-> (word[10:9] == 2'b00));
  a_r8_busy_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state == S_DIV1 && start) |=> (state == S_DIV1 || state == S_DIV2));
endmodule

// File: tb/fsyn_word_enc_tb.sv
`timescale 1ns/1ps
module fsyn_word_enc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] freq = '0;
  logic [12:0] word;
  logic [3:0]  pdiv;
  logic        done;
  logic        err;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fsyn_word_enc u_dut (
    .clk(clk), .rst(rst), .start(start), .freq(freq),
    .word(word), .pdiv(pdiv), .done(done), .err(err)
  );

  // {err, pdiv, freq}
  localparam logic [20:0] TBL [14] = '{
    {1'b0, 4'd1, 16'd8000},  {1'b0, 4'd1, 16'd15938}, {1'b0, 4'd8, 16'd1000},
    {1'b0, 4'd8, 16'd1999},  {1'b0, 4'd2, 16'd4000},  {1'b0, 4'd2, 16'd5000},
    {1'b0, 4'd4, 16'd3999},  {1'b0, 4'd1, 16'd12345}, {1'b0, 4'd4, 16'd2500},
    {1'b0, 4'd2, 16'd7999},  {1'b1, 4'd0, 16'd15939}, {1'b1, 4'd0, 16'd999},
    {1'b1, 4'd0, 16'd0},     {1'b1, 4'd0, 16'd65535}
  };

  function automatic logic [12:0] model_word(input int f);
    longint v;
    longint n;
    int p;
    logic [1:0] c;
    if (f > 15938 || f < 1000) return 13'd0;
    v = f;
    p = 1;
    while (v < 8000) begin v = v * 2; p = p * 2; end
    n = ((v * 46000) / 1432 + 500) / 1000;
    c = (p == 1) ? 2'b11 : (p == 2) ? 2'b10 : (p == 4) ? 2'b01 : 2'b00;
    return {2'b11, c, 9'(n - 257)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [15:0] f);
    @(negedge clk);
    freq  = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit seen;
    logic [12:0] held;
    repeat (3) @(negedge clk);
    check(word == 0 && pdiv == 0 && !done && !err, "R9 reset state", {word, pdiv}, 0);
    rst = 1'b0;

    for (int k = 0; k < 14; k++) begin
      logic [15:0] f;
      logic [3:0] ep;
      logic ee;
      f  = TBL[k][15:0];
      ep = TBL[k][19:16];
      ee = TBL[k][20];
      pulse_start(f);
      wait_done(seen);
      check(seen, "R7 done seen", int'(seen), 1);
      check(err == ee, ee ? "R1/R2 err" : "R6 err low", int'(err), int'(ee));
      check(pdiv == ep, "R3 pdiv", int'(pdiv), int'(ep));
      check(word == model_word(int'(f)), "R4 R5 R6 word", int'(word), int'(model_word(int'(f))));
      held = word;
      @(negedge clk);
      check(!done, "R7 single pulse", int'(done), 0);
      check(word == held, "R7 hold", int'(word), int'(held));
    end

    // R4/R5/R6 hand-computed corner words
    pulse_start(16'd8000);
    wait_done(seen);
    check(word == 13'h1E00, "R4 vco low edge", int'(word), 'h1E00);
    pulse_start(16'd1999);
    wait_done(seen);
    check(word == 13'h1901, "R4 field 0x101", int'(word), 'h1901);
    pulse_start(16'd15938);
    wait_done(seen);
    check(word == 13'h1EFF && !err, "R2 upper limit accepted", int'(word), 'h1EFF);

    // R8: second start during conversion is ignored
    pulse_start(16'd8000);
    repeat (3) @(negedge clk);
    pulse_start(16'd1000);
    wait_done(seen);
    check(word == 13'h1E00 && pdiv == 4'd1, "R8 first request wins", int'(word), 'h1E00);
    @(negedge clk);
    seen = 1'b0;
    for (int i = 0; i < 150; i++) begin
      if (done) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R8 no second result", int'(seen), 0);

    // R9: reset in the middle of a division
    pulse_start(16'd2500);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(word == 0 && pdiv == 0 && !err && !done, "R9 reset clears", {word, pdiv}, 0);
    seen = 1'b0;
    for (int i = 0; i < 150; i++) begin
      if (done) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R9 no done after reset", int'(seen), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule